// File: doc/BRIEF.md
# Multi-Master OR-Combining Pin Data Crossbar

This block links a set of processor cores to a larger set of peripheral pin cells over full-width parallel paths. Every core presents one data word, a pin index and a write enable in each cycle. The word travels to the addressed pin cell. No arbiter sits in the path. When two or more enabled cores address the same pin in the same cycle, the pin receives the bitwise OR of their words, and no core outranks another.

The return path gives each core a registered view of the output word of the pin it currently addresses. A core requests a read by raising its read enable. One clock edge later, its read-data register holds the addressed pin's word and its valid flag is high. Both directions move whole words through a single register stage, with no serial shifting and no handshake.

Top module: `pinxbar_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, every pin word, every pin strobe, every core read word and every core valid flag is zero.
- R2: Core c supplies its index in bits [c*6 +: 6] of the select bus, with values 0 to 63, and its word in bits [c*32 +: 32] of the write bus. Pin p occupies bits [p*32 +: 32] of the pin buses. If core c is enabled at a rising edge, its word appears on pin p's word output for the cycle after that edge. This includes pins 0 and 63.
- R3: A pin's strobe is high in the cycle after an edge exactly when at least one enabled core addressed that pin at the edge.
- R4: When several enabled cores address the same pin at one edge, that pin's word in the following cycle is the bitwise OR of all their words, with no priority.
- R5: A core whose write enable is low has no effect on any pin. A pin that no enabled core addresses shows an all-zero word and a low strobe in the following cycle.
- R6: When a core's read enable is high at an edge, its read word in the following cycle equals the word that its addressed pin presented on the pin read bus at that edge, and its valid flag is high.
- R7: When a core's read enable is low at an edge, its read word keeps its previous value and its valid flag is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_wen_i | input | 16 | Per-core write enable |
| core_sel_i | input | 96 | Per-core pin index, 6 bits per core |
| core_wdata_i | input | 512 | Per-core write word, 32 bits per core |
| core_ren_i | input | 16 | Per-core read enable |
| core_rdata_o | output | 512 | Per-core registered read word |
| core_rvalid_o | output | 16 | Per-core read valid flag |
| pin_word_o | output | 2048 | Registered merged word per pin |
| pin_stb_o | output | 64 | Registered write strobe per pin |
| pin_rdata_i | input | 2048 | Output word of each pin cell |

## Verification
All results of this block are due exactly one rising edge after the stimulus that causes them. The merged pin words, the pin strobes, the read words and the valid flags all pass through a single register. The bench applies each stimulus on a falling edge and lets one rising edge pass. It compares every output bus at the next falling edge, before it drives the next stimulus. For the hold case, the bench carries forward the read word it expected last time.

// File: rtl/pinxbar_pkg.sv
package pinxbar_pkg;

    localparam int unsigned XB_CORES = 16;
    localparam int unsigned XB_PINS  = 64;
    localparam int unsigned XB_WORD  = 32;

    // Index width for a count, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pinxbar_sel_dec.sv
module pinxbar_sel_dec #(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned SEL_W    = 6
) (
    input  logic                en,
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_PINS-1:0] hit
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign hit[p] = en && (sel == SEL_W'(p));
    end

    // A core reaches at most one pin, and none when it is disabled.
    always_comb begin
        p_dec_onehot_r2: assert ($onehot0(hit));
        p_dec_quiet_r5:  assert (en || (hit == '0));
    end

endmodule

// File: rtl/pinxbar_wr_merge.sv
module pinxbar_wr_merge #(
    parameter int unsigned NUM_CORES = 16,
    parameter int unsigned NUM_PINS  = 64,
    parameter int unsigned DATA_W    = 32
) (
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0] hit_mat,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]   core_word,
    output logic [NUM_PINS-1:0][DATA_W-1:0]    pin_word_nxt,
    output logic [NUM_PINS-1:0]                pin_stb_nxt
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            pin_word_nxt[p] = '0;
            pin_stb_nxt[p]  = 1'b0;
            for (int c = 0; c < NUM_CORES; c++) begin
                if (hit_mat[c][p]) begin
                    pin_word_nxt[p] = pin_word_nxt[p] | core_word[c];
                    pin_stb_nxt[p]  = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pinxbar_rd_port.sv
module pinxbar_rd_port #(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SEL_W    = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ren,
    input  logic [SEL_W-1:0]                 sel,
    input  logic [NUM_PINS-1:0][DATA_W-1:0]  pin_out,
    output logic [DATA_W-1:0]                rdata,
    output logic                             rvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= ren;
            if (ren) begin
                rdata <= pin_out[sel];
            end
        end
    end

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        ren |=> rvalid);

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !ren |=> ($stable(rdata) && !rvalid));

endmodule

// File: rtl/pinxbar_top.sv
module pinxbar_top
    import pinxbar_pkg::*;
#(
    parameter int unsigned NUM_CORES = XB_CORES,
    parameter int unsigned NUM_PINS  = XB_PINS,
    parameter int unsigned DATA_W    = XB_WORD,
    localparam int unsigned SEL_W    = idx_width(NUM_PINS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          core_wen_i,
    input  logic [NUM_CORES*SEL_W-1:0]    core_sel_i,
    input  logic [NUM_CORES*DATA_W-1:0]   core_wdata_i,
    input  logic [NUM_CORES-1:0]          core_ren_i,
    output logic [NUM_CORES*DATA_W-1:0]   core_rdata_o,
    output logic [NUM_CORES-1:0]          core_rvalid_o,
    output logic [NUM_PINS*DATA_W-1:0]    pin_word_o,
    output logic [NUM_PINS-1:0]           pin_stb_o,
    input  logic [NUM_PINS*DATA_W-1:0]    pin_rdata_i
);

    logic [NUM_CORES-1:0][SEL_W-1:0]      sel_arr;
    logic [NUM_CORES-1:0][DATA_W-1:0]     wdata_arr;
    logic [NUM_CORES-1:0][NUM_PINS-1:0]   hit_mat;
    logic [NUM_PINS-1:0][DATA_W-1:0]      pin_rd_arr;
    logic [NUM_PINS-1:0][DATA_W-1:0]      word_nxt;
    logic [NUM_PINS-1:0]                  stb_nxt;
    logic [NUM_PINS-1:0][DATA_W-1:0]      pin_word_q;
    logic [NUM_PINS-1:0]                  pin_stb_q;

    assign sel_arr    = core_sel_i;
    assign wdata_arr  = core_wdata_i;
    assign pin_rd_arr = pin_rdata_i;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        pinxbar_sel_dec #(
            .NUM_PINS (NUM_PINS),
            .SEL_W    (SEL_W)
        ) u_dec (
            .en  (core_wen_i[c]),
            .sel (sel_arr[c]),
            .hit (hit_mat[c])
        );

        pinxbar_rd_port #(
            .NUM_PINS (NUM_PINS),
            .DATA_W   (DATA_W),
            .SEL_W    (SEL_W)
        ) u_rd (
            .clk     (clk),
            .rst     (rst),
            .ren     (core_ren_i[c]),
            .sel     (sel_arr[c]),
            .pin_out (pin_rd_arr),
            .rdata   (core_rdata_o[c*DATA_W +: DATA_W]),
            .rvalid  (core_rvalid_o[c])
        );
    end

    pinxbar_wr_merge #(
        .NUM_CORES (NUM_CORES),
        .NUM_PINS  (NUM_PINS),
        .DATA_W    (DATA_W)
    ) u_merge (
        .hit_mat      (hit_mat),
        .core_word    (wdata_arr),
        .pin_word_nxt (word_nxt),
        .pin_stb_nxt  (stb_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_word_q <= '0;
            pin_stb_q  <= '0;
        end else begin
            pin_word_q <= word_nxt;
            pin_stb_q  <= stb_nxt;
        end
    end

    assign pin_word_o = pin_word_q;
    assign pin_stb_o  = pin_stb_q;

    // Records of the previous write request, used only by the checks below.
    logic [NUM_CORES-1:0]              last_wen_q;
    logic [NUM_CORES-1:0][SEL_W-1:0]   last_sel_q;
    logic [NUM_CORES-1:0][DATA_W-1:0]  last_word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_wen_q  <= '0;
            last_sel_q  <= '0;
            last_word_q <= '0;
        end else begin
            last_wen_q  <= core_wen_i;
            last_sel_q  <= sel_arr;
            last_word_q <= wdata_arr;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk_core
        p_target_strobed_r3: assert property (@(posedge clk) disable iff (rst)
            last_wen_q[c] |-> pin_stb_q[last_sel_q[c]]);

        p_bits_delivered_r4: assert property (@(posedge clk) disable iff (rst)
            last_wen_q[c] |->
                ((pin_word_q[last_sel_q[c]] & last_word_q[c]) == last_word_q[c]));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk_pin
        p_idle_pin_zero_r5: assert property (@(posedge clk) disable iff (rst)
            !pin_stb_q[p] |-> (pin_word_q[p] == '0));
    end

endmodule

// File: tb/pinxbar_top_tb_top.sv
module pinxbar_top_tb_top;

    localparam int NC = 16;
    localparam int NP = 64;
    localparam int DW = 32;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NC-1:0]    wen;
    logic [NC-1:0]    ren;
    logic [SW-1:0]    sel   [NC];
    logic [DW-1:0]    wd    [NC];
    logic [DW-1:0]    prd   [NP];

    logic [NC*SW-1:0] core_sel_v;
    logic [NC*DW-1:0] core_wdata_v;
    logic [NP*DW-1:0] pin_rdata_v;
    logic [NC*DW-1:0] core_rdata_o;
    logic [NC-1:0]    core_rvalid_o;
    logic [NP*DW-1:0] pin_word_o;
    logic [NP-1:0]    pin_stb_o;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            core_sel_v[c*SW +: SW]   = sel[c];
            core_wdata_v[c*DW +: DW] = wd[c];
        end
        for (int p = 0; p < NP; p++) pin_rdata_v[p*DW +: DW] = prd[p];
    end

    pinxbar_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .core_wen_i    (wen),
        .core_sel_i    (core_sel_v),
        .core_wdata_i  (core_wdata_v),
        .core_ren_i    (ren),
        .core_rdata_o  (core_rdata_o),
        .core_rvalid_o (core_rvalid_o),
        .pin_word_o    (pin_word_o),
        .pin_stb_o     (pin_stb_o),
        .pin_rdata_i   (pin_rdata_v)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [NP*DW-1:0] exp_word;
    logic [NP-1:0]    exp_stb;
    logic [NC*DW-1:0] exp_rd;
    logic [NC-1:0]    exp_rv;

    task automatic chk(input string req, input logic [NP*DW-1:0] act,
                       input logic [NP*DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected values from the requirements, computed from the applied stimulus.
    task automatic predict();
        exp_word = '0;
        exp_stb  = '0;
        for (int c = 0; c < NC; c++) begin
            if (wen[c]) begin
                exp_word[sel[c]*DW +: DW] = exp_word[sel[c]*DW +: DW] | wd[c];
                exp_stb[sel[c]] = 1'b1;
            end
            if (ren[c]) exp_rd[c*DW +: DW] = prd[sel[c]];
        end
        exp_rv = ren;
    endtask

    task automatic step();
        predict();
        @(posedge clk);
        @(negedge clk);
        chk("R2 R4 R5 pin words", pin_word_o, exp_word);
        chk("R3 pin strobes", {{(NP*DW-NP){1'b0}}, pin_stb_o}, {{(NP*DW-NP){1'b0}}, exp_stb});
        chk("R6 R7 read words", {{(NP*DW-NC*DW){1'b0}}, core_rdata_o},
            {{(NP*DW-NC*DW){1'b0}}, exp_rd});
        chk("R6 R7 valid flags", {{(NP*DW-NC){1'b0}}, core_rvalid_o},
            {{(NP*DW-NC){1'b0}}, exp_rv});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        wen = '1;
        ren = '1;
        for (int c = 0; c < NC; c++) begin
            sel[c] = SW'(c);
            wd[c]  = 32'hA5A5_0000 | c;
        end
        for (int p = 0; p < NP; p++) prd[p] = 32'hC0DE_0000 | p;
        exp_rd = '0;

        // R1: outputs stay zero under reset despite active inputs.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pin words in reset", pin_word_o, '0);
        chk("R1 strobes in reset", {{(NP*DW-NP){1'b0}}, pin_stb_o}, '0);
        chk("R1 read words in reset", {{(NP*DW-NC*DW){1'b0}}, core_rdata_o}, '0);
        chk("R1 valid in reset", {{(NP*DW-NC){1'b0}}, core_rvalid_o}, '0);
        wen = '0;
        ren = '0;
        rst = 1'b0;
        step();

        // R4: all cores hit pin 63 with one bit each, giving 0x0000FFFF.
        for (int c = 0; c < NC; c++) begin
            sel[c] = 6'd63;
            wd[c]  = 32'h1 << c;
        end
        wen = '1;
        ren = '1;
        step();
        chk("R4 all cores merged at pin 63", {{(NP*DW-DW){1'b0}}, pin_word_o[63*DW +: DW]},
            {{(NP*DW-DW){1'b0}}, 32'h0000_FFFF});

        // R5: disabled cores with live data change nothing.
        wen = '0;
        ren = '0;
        for (int c = 0; c < NC; c++) wd[c] = 32'hFFFF_FFFF;
        step();

        // R2: only core 15 writes, to pin 0.
        wen = 16'h8000;
        sel[15] = 6'd0;
        wd[15]  = 32'hDEAD_BEEF;
        step();
        chk("R2 core 15 to pin 0", {{(NP*DW-DW){1'b0}}, pin_word_o[DW-1:0]},
            {{(NP*DW-DW){1'b0}}, 32'hDEAD_BEEF});

        // R7: read disabled while pin data changes; read words must hold.
        for (int p = 0; p < NP; p++) prd[p] = $urandom;
        ren = '0;
        step();

        // Random traffic with frequent collisions.
        for (int i = 0; i < 400; i++) begin
            wen = 16'($urandom);
            ren = 16'($urandom);
            for (int c = 0; c < NC; c++) begin
                sel[c] = (i % 3 == 0) ? SW'($urandom % 4) : SW'($urandom);
                wd[c]  = $urandom;
            end
            for (int p = 0; p < NP; p++) prd[p] = $urandom;
            step();
        end

        summary();
    end

endmodule